// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Sequencer

This block is the command front end of a byte-wide NOR flash. It watches the chip-enable, output-enable and write-enable strobes of an asynchronous parallel bus. It brings them into a system clock domain and decodes the multi-write unlock and command sequences a host writes to start operations. A small state machine moves the device between plain array reads, identifier reads, byte programming, sector or whole-chip erase, a paused erase, and a shortcut mode in which each program needs only two writes. A plain data byte that is not part of a valid sequence sends the machine back to array reads.

The embedded program and erase algorithms are modelled by cycle counters. While one of them runs, the ready output is low. A compact array model holds a few bytes per sector. Programming can only clear bits, so the stored byte becomes the AND of the old byte and the written byte. Erase sets the bytes back to FFh. Each sector has a protect input that blocks changes to it.

The bus has no handshake. A write takes effect on the rising edge of the write strobe, after synchronisation. The host learns that an operation has finished by watching the ready output. There is no back-pressure: a write that arrives while an operation is running is dropped, unless it is an erase-suspend. Reads return a registered byte, with an output-enable flag that stands in for the tristate control.

Top module: `flash_cmd_seq`

## Requirements
- R1: After power-on reset the sequencer reads the array and the ready output is high. The array is erased, so every byte reads FFh. A read returns the byte held for sector `addr[21:16]` at offset `addr[1:0]`. `dout_oe` is high only while both `ce_n` and `oe_n` are low.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then data@target programs one byte. The unlock offsets are compared on `addr[10:0]`. The stored byte becomes old AND data. `rdy` goes low once the last write has been decoded and stays low for PROG_CYC cycles.
- R3: A wrong data value or a wrong unlock offset anywhere in a sequence returns the machine to array reads. The writes that follow then start nothing.
- R4: While `hw_rst_n` is low, the block ends any running operation without changing the array, keeps `dout_oe` low and ignores all writes. After release the block reads the array.
- R5: If `hw_rst_n` falls while an operation runs, `rdy` stays low for RST_BUSY_CYC cycles. If it falls while the block is idle, `rdy` stays high.
- R6: The sequence AAh@555h, 55h@2AAh, 90h@555h enters identifier mode. In this mode, reads at `addr[1:0]`=0 return 01h and at 1 return A3h. At 2 they return 01h if the addressed sector is protected and 00h if it is not. F0h exits to array reads. Any other write leaves identifier mode in place.
- R7: AAh, 55h, 80h, AAh, 55h, then 30h at any address in a sector erases that one sector to FFh. Ending with 10h@555h instead erases every unprotected sector. `rdy` is low for ERASE_CYC cycles, and other sectors keep their contents.
- R8: While `rdy` is low because of an operation, writes are ignored. The one exception is B0h during an erase.
- R9: B0h during an erase pauses it and `rdy` returns high. While paused, reads return array data and a full four-write program can run in another sector. When that program ends the erase is still paused. 30h resumes the erase, which then finishes.
- R10: AAh@555h, 55h@2AAh, 20h@555h enters shortcut mode. In shortcut mode A0h at any address followed by data@target programs a byte and the block stays in shortcut mode. Any other single write also leaves the mode in place. 90h followed by 00h returns to array reads.
- R11: Program and erase leave a sector unchanged while its `sect_prot` bit is set, although `rdy` still goes low for the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; a write takes effect on its rising edge |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| addr | input | ADDR_W (22) | Byte address; the top SECT_BITS bits select the sector |
| din | input | 8 | Write data |
| sect_prot | input | 2**SECT_BITS (64) | Per-sector protect flags |
| dout | output | 8 | Read data: array byte or identifier code |
| dout_oe | output | 1 | High when `dout` should be driven onto the bus |
| rdy | output | 1 | Ready (high) / busy (low) |

## Verification
A table of bus writes and reads runs the sequencer through several kinds of input. Complete four-write programs show the AND-only storage rule. Sequences broken by a bad data byte, a bad command byte or a bad unlock offset must all leave the array untouched. Identifier reads at each offset tell the identifier register apart from array data. Shortcut-mode programs with a stray write in between show that the mode holds, and the exit pair shows that it ends. Erases separate the target sector from its neighbours. A paused erase with a program in a second sector shows that the two counters are independent. Directed tests pull the hardware reset during a program and while idle to check the two ready behaviours.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int UNLK_W = 11;
  localparam logic [UNLK_W-1:0] UNLK_ADDR_A = 11'h555;
  localparam logic [UNLK_W-1:0] UNLK_ADDR_B = 11'h2AA;

  localparam logic [7:0] KEY_A       = 8'hAA;
  localparam logic [7:0] KEY_B       = 8'h55;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_PROG     = 8'hA0;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_SECT     = 8'h30;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_FAST     = 8'h20;
  localparam logic [7:0] OP_PAUSE    = 8'hB0;
  localparam logic [7:0] OP_RESUME   = 8'h30;
  localparam logic [7:0] OP_EXIT     = 8'hF0;
  localparam logic [7:0] OP_FAST_END = 8'h00;

  localparam logic [7:0] ID_MAKER  = 8'h01;
  localparam logic [7:0] ID_DEVICE = 8'hA3;

  typedef enum logic [4:0] {
    S_RD, S_U1, S_U2, S_AS, S_PGA,
    S_E1, S_E2, S_E3,
    S_PBUSY, S_EBUSY,
    S_SUSP, S_SU1, S_SU2, S_SPGA, S_SPBUSY,
    S_BY, S_BYPGA, S_BYEX
  } seq_st_e;

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hw_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              hw_act
);

  logic [1:0] we_sy, ce_sy, oe_sy, rs_sy;
  logic       we_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_sy   <= 2'b11;
      ce_sy   <= 2'b11;
      oe_sy   <= 2'b11;
      rs_sy   <= 2'b00;
      we_d    <= 1'b1;
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_sy <= {we_sy[0], we_n};
      ce_sy <= {ce_sy[0], ce_n};
      oe_sy <= {oe_sy[0], oe_n};
      rs_sy <= {rs_sy[0], hw_rst_n};
      we_d  <= we_sy[1];
      // address captured as the strobe falls
      if (!we_sy[1] && we_d)
        wr_addr <= addr;
      // data captured and the write issued as the strobe rises
      if (we_sy[1] && !we_d && !ce_sy[1] && oe_sy[1] && rs_sy[1]) begin
        wr_evt  <= 1'b1;
        wr_data <= din;
      end else begin
        wr_evt  <= 1'b0;
      end
    end
  end

  assign rd_act = !ce_sy[1] && !oe_sy[1];
  assign hw_act = !rs_sy[1];

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model #(
  parameter int SECT_BITS = 6,
  parameter int WIN_BITS  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pg_we,
  input  logic [SECT_BITS+WIN_BITS-1:0] pg_idx,
  input  logic [7:0]                    pg_data,
  input  logic                          er_en,
  input  logic [(1<<SECT_BITS)-1:0]     er_mask,
  input  logic [SECT_BITS+WIN_BITS-1:0] rd_idx,
  output logic [7:0]                    rd_data
);

  localparam int DEPTH = 1 << (SECT_BITS + WIN_BITS);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (er_en) begin
        for (int i = 0; i < DEPTH; i++)
          if (er_mask[i >> WIN_BITS]) mem[i] <= 8'hFF;
      end else if (pg_we) begin
        mem[pg_idx] <= mem[pg_idx] & pg_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int SECT_BITS    = 6,
  parameter int WIN_BITS     = 2,
  parameter int PROG_CYC     = 40,
  parameter int ERASE_CYC    = 200,
  parameter int RST_BUSY_CYC = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_evt,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic                          hw_act,
  input  logic [(1<<SECT_BITS)-1:0]     sect_prot,
  output seq_st_e                       st,
  output logic                          rdy,
  output logic                          pg_we,
  output logic [SECT_BITS+WIN_BITS-1:0] pg_idx,
  output logic [7:0]                    pg_data,
  output logic                          er_en,
  output logic [(1<<SECT_BITS)-1:0]     er_mask
);

  localparam int NSECT = 1 << SECT_BITS;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);
  localparam int RCW   = $clog2(RST_BUSY_CYC + 1);

  logic [PCW-1:0]       pcnt;
  logic [ECW-1:0]       ecnt;
  logic [RCW-1:0]       rcnt;
  logic                 p_ok, p_from_by;
  logic [NSECT-1:0]     emask;

  logic [SECT_BITS-1:0] w_sect;
  logic                 at_a, at_b, busy_st;
  logic                 unused_addr;

  assign w_sect      = wr_addr[ADDR_W-1 -: SECT_BITS];
  assign at_a        = wr_addr[UNLK_W-1:0] == UNLK_ADDR_A;
  assign at_b        = wr_addr[UNLK_W-1:0] == UNLK_ADDR_B;
  assign busy_st     = st inside {S_PBUSY, S_EBUSY, S_SPBUSY};
  assign unused_addr = ^wr_addr;

  assign rdy     = !busy_st && (rcnt == '0);
  assign pg_we   = (st == S_PBUSY || st == S_SPBUSY) && pcnt == PCW'(1) && p_ok && !hw_act;
  assign er_en   = (st == S_EBUSY) && ecnt == ECW'(1) && !hw_act;
  assign er_mask = emask;

  task automatic take_prog(input logic ok, input logic from_by, input seq_st_e nxt);
    pg_idx    <= {w_sect, wr_addr[WIN_BITS-1:0]};
    pg_data   <= wr_data;
    p_ok      <= ok;
    p_from_by <= from_by;
    pcnt      <= PCW'(PROG_CYC);
    st        <= nxt;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RD;
      pcnt      <= '0;
      ecnt      <= '0;
      rcnt      <= '0;
      p_ok      <= 1'b0;
      p_from_by <= 1'b0;
      pg_idx    <= '0;
      pg_data   <= '0;
      emask     <= '0;
    end else if (hw_act) begin
      st   <= S_RD;
      pcnt <= '0;
      ecnt <= '0;
      if (busy_st)          rcnt <= RCW'(RST_BUSY_CYC);
      else if (rcnt != '0)  rcnt <= rcnt - RCW'(1);
    end else begin
      if (rcnt != '0) rcnt <= rcnt - RCW'(1);
      case (st)
        S_PBUSY: begin
          pcnt <= pcnt - PCW'(1);
          if (pcnt == PCW'(1)) st <= p_from_by ? S_BY : S_RD;
        end
        S_SPBUSY: begin
          pcnt <= pcnt - PCW'(1);
          if (pcnt == PCW'(1)) st <= S_SUSP;
        end
        S_EBUSY: begin
          if (wr_evt && wr_data == OP_PAUSE && ecnt != ECW'(1)) begin
            st <= S_SUSP;
          end else begin
            ecnt <= ecnt - ECW'(1);
            if (ecnt == ECW'(1)) st <= S_RD;
          end
        end
        default: if (wr_evt) begin
          case (st)
            S_RD:  st <= (wr_data == KEY_A && at_a) ? S_U1 : S_RD;
            S_U1:  st <= (wr_data == KEY_B && at_b) ? S_U2 : S_RD;
            S_U2: begin
              if (!at_a)                     st <= S_RD;
              else if (wr_data == OP_IDENT)  st <= S_AS;
              else if (wr_data == OP_PROG)   st <= S_PGA;
              else if (wr_data == OP_ERASE)  st <= S_E1;
              else if (wr_data == OP_FAST)   st <= S_BY;
              else                           st <= S_RD;
            end
            S_AS:  if (wr_data == OP_EXIT) st <= S_RD;
            S_PGA: take_prog(!sect_prot[w_sect], 1'b0, S_PBUSY);
            S_E1:  st <= (wr_data == KEY_A && at_a) ? S_E2 : S_RD;
            S_E2:  st <= (wr_data == KEY_B && at_b) ? S_E3 : S_RD;
            S_E3: begin
              if (wr_data == OP_SECT) begin
                emask <= (NSECT'(1) << w_sect) & ~sect_prot;
                ecnt  <= ECW'(ERASE_CYC);
                st    <= S_EBUSY;
              end else if (wr_data == OP_CHIP && at_a) begin
                emask <= ~sect_prot;
                ecnt  <= ECW'(ERASE_CYC);
                st    <= S_EBUSY;
              end else begin
                st <= S_RD;
              end
            end
            S_SUSP: begin
              if (wr_data == OP_RESUME)           st <= S_EBUSY;
              else if (wr_data == KEY_A && at_a)  st <= S_SU1;
            end
            S_SU1: st <= (wr_data == KEY_B && at_b) ? S_SU2 : S_SUSP;
            S_SU2: st <= (wr_data == OP_PROG && at_a) ? S_SPGA : S_SUSP;
            S_SPGA: take_prog(!sect_prot[w_sect] && !emask[w_sect], 1'b0, S_SPBUSY);
            S_BY: begin
              if (wr_data == OP_PROG)       st <= S_BYPGA;
              else if (wr_data == OP_IDENT) st <= S_BYEX;
            end
            S_BYPGA: take_prog(!sect_prot[w_sect], 1'b1, S_PBUSY);
            S_BYEX:  st <= (wr_data == OP_FAST_END) ? S_RD : S_BY;
            default: st <= S_RD;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int SECT_BITS    = 6,
  parameter int WIN_BITS     = 2,
  parameter int PROG_CYC     = 40,
  parameter int ERASE_CYC    = 200,
  parameter int RST_BUSY_CYC = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      oe_n,
  input  logic                      we_n,
  input  logic                      hw_rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                din,
  input  logic [(1<<SECT_BITS)-1:0] sect_prot,
  output logic [7:0]                dout,
  output logic                      dout_oe,
  output logic                      rdy
);

  localparam int IDX_W = SECT_BITS + WIN_BITS;

  logic                      wr_evt, rd_act, hw_act;
  logic [ADDR_W-1:0]         wr_addr;
  logic [7:0]                wr_data;
  seq_st_e                   st;
  logic                      pg_we, er_en;
  logic [IDX_W-1:0]          pg_idx, rd_idx;
  logic [7:0]                pg_data, arr_q, id_q;
  logic [(1<<SECT_BITS)-1:0] er_mask;
  logic [SECT_BITS-1:0]      rd_sect;
  logic                      unused_rd;

  flash_bus_sync #(.ADDR_W(ADDR_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .addr(addr), .din(din),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_act(rd_act), .hw_act(hw_act)
  );

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .WIN_BITS(WIN_BITS),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .RST_BUSY_CYC(RST_BUSY_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .hw_act(hw_act), .sect_prot(sect_prot),
    .st(st), .rdy(rdy), .pg_we(pg_we), .pg_idx(pg_idx), .pg_data(pg_data),
    .er_en(er_en), .er_mask(er_mask)
  );

  flash_array_model #(.SECT_BITS(SECT_BITS), .WIN_BITS(WIN_BITS)) u_array (
    .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_idx(pg_idx),
    .pg_data(pg_data), .er_en(er_en), .er_mask(er_mask),
    .rd_idx(rd_idx), .rd_data(arr_q)
  );

  assign rd_sect   = addr[ADDR_W-1 -: SECT_BITS];
  assign rd_idx    = {rd_sect, addr[WIN_BITS-1:0]};
  assign unused_rd = ^addr;

  always_comb begin
    case (addr[1:0])
      2'd0:    id_q = ID_MAKER;
      2'd1:    id_q = ID_DEVICE;
      2'd2:    id_q = {7'd0, sect_prot[rd_sect]};
      default: id_q = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= (st == S_AS) ? id_q : arr_q;
      dout_oe <= rd_act && !hw_act;
    end
  end

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       hw_act,
  input logic       wr_evt,
  input logic [7:0] wr_data,
  input seq_st_e    st,
  input logic       rdy,
  input logic       dout_oe,
  input logic       pg_we,
  input logic       er_en
);

  p_reset_to_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_act |=> st == S_RD);

  p_quiet_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_act |=> !dout_oe);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !hw_act && st == S_PGA) |=> !rdy);

  p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_we || er_en) |-> !rdy);

  p_pause_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EBUSY && wr_evt && wr_data == OP_PAUSE && !hw_act) |=> (st == S_SUSP || st == S_RD));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_act(hw_act), .wr_evt(wr_evt),
  .wr_data(wr_data), .st(st), .rdy(rdy), .dout_oe(dout_oe),
  .pg_we(pg_we), .er_en(er_en)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam logic [2:0] KW = 3'd0, KR = 3'd1, KWR = 3'd2, KB = 3'd3, KY = 3'd4;

  typedef struct packed {
    logic [2:0]  k;
    logic [21:0] a;
    logic [7:0]  d;
    logic [3:0]  r;
  } vec_t;

  localparam int N = 133;
  localparam vec_t VEC [N] = '{
    // R1 erased array after power-on
    '{KR, 22'h000000, 8'hFF, 4'd1},
    // R2 four-write program, then a second program of the same byte (AND)
    '{KW, 22'h000555, 8'hAA, 4'd2}, '{KW, 22'h0002AA, 8'h55, 4'd2},
    '{KW, 22'h000555, 8'hA0, 4'd2}, '{KW, 22'h030001, 8'h5A, 4'd2},
    '{KB, 22'h0, 8'h0, 4'd2}, '{KWR, 22'h0, 8'h0, 4'd2},
    '{KR, 22'h030001, 8'h5A, 4'd2},
    '{KW, 22'h000555, 8'hAA, 4'd2}, '{KW, 22'h0002AA, 8'h55, 4'd2},
    '{KW, 22'h000555, 8'hA0, 4'd2}, '{KW, 22'h030001, 8'h0F, 4'd2},
    '{KWR, 22'h0, 8'h0, 4'd2}, '{KR, 22'h030001, 8'h0A, 4'd2},
    '{KW, 22'h000555, 8'hAA, 4'd2}, '{KW, 22'h0002AA, 8'h55, 4'd2},
    '{KW, 22'h000555, 8'hA0, 4'd2}, '{KW, 22'h040000, 8'h33, 4'd2},
    '{KWR, 22'h0, 8'h0, 4'd2}, '{KR, 22'h040000, 8'h33, 4'd2},
    // R3 bad second key, bad command, bad unlock offset
    '{KW, 22'h000555, 8'hAA, 4'd3}, '{KW, 22'h0002AA, 8'h56, 4'd3},
    '{KW, 22'h000555, 8'hA0, 4'd3}, '{KW, 22'h030002, 8'h00, 4'd3},
    '{KY, 22'h0, 8'h0, 4'd3}, '{KR, 22'h030002, 8'hFF, 4'd3},
    '{KW, 22'h000555, 8'hAA, 4'd3}, '{KW, 22'h0002AA, 8'h55, 4'd3},
    '{KW, 22'h000555, 8'h77, 4'd3}, '{KW, 22'h030002, 8'h00, 4'd3},
    '{KR, 22'h030002, 8'hFF, 4'd3},
    '{KW, 22'h000555, 8'hAA, 4'd3}, '{KW, 22'h0002AB, 8'h55, 4'd3},
    '{KW, 22'h000555, 8'h90, 4'd3}, '{KR, 22'h000001, 8'hFF, 4'd3},
    // R6 identifier mode, R11 protect flag at offset 2
    '{KW, 22'h000555, 8'hAA, 4'd6}, '{KW, 22'h0002AA, 8'h55, 4'd6},
    '{KW, 22'h000555, 8'h90, 4'd6}, '{KR, 22'h000000, 8'h01, 4'd6},
    '{KR, 22'h000001, 8'hA3, 4'd6}, '{KR, 22'h050002, 8'h01, 4'd11},
    '{KR, 22'h030002, 8'h00, 4'd6}, '{KW, 22'h000000, 8'h12, 4'd6},
    '{KR, 22'h000001, 8'hA3, 4'd6}, '{KW, 22'h000000, 8'hF0, 4'd6},
    '{KR, 22'h030001, 8'h0A, 4'd6},
    // R7 sector erase of sector 3
    '{KW, 22'h000555, 8'hAA, 4'd7}, '{KW, 22'h0002AA, 8'h55, 4'd7},
    '{KW, 22'h000555, 8'h80, 4'd7}, '{KW, 22'h000555, 8'hAA, 4'd7},
    '{KW, 22'h0002AA, 8'h55, 4'd7}, '{KW, 22'h030000, 8'h30, 4'd7},
    '{KB, 22'h0, 8'h0, 4'd7}, '{KWR, 22'h0, 8'h0, 4'd7},
    '{KR, 22'h030001, 8'hFF, 4'd7}, '{KR, 22'h040000, 8'h33, 4'd7},
    // R10 shortcut mode
    '{KW, 22'h000555, 8'hAA, 4'd10}, '{KW, 22'h0002AA, 8'h55, 4'd10},
    '{KW, 22'h000555, 8'h20, 4'd10}, '{KW, 22'h000000, 8'hA0, 4'd10},
    '{KW, 22'h060003, 8'hC3, 4'd10}, '{KB, 22'h0, 8'h0, 4'd10},
    '{KWR, 22'h0, 8'h0, 4'd10}, '{KR, 22'h060003, 8'hC3, 4'd10},
    '{KW, 22'h000000, 8'hA0, 4'd10}, '{KW, 22'h060002, 8'h3C, 4'd10},
    '{KWR, 22'h0, 8'h0, 4'd10}, '{KR, 22'h060002, 8'h3C, 4'd10},
    '{KW, 22'h000000, 8'h77, 4'd10}, '{KW, 22'h000000, 8'hA0, 4'd10},
    '{KW, 22'h060001, 8'h11, 4'd10}, '{KWR, 22'h0, 8'h0, 4'd10},
    '{KR, 22'h060001, 8'h11, 4'd10}, '{KW, 22'h000000, 8'h90, 4'd10},
    '{KW, 22'h000000, 8'h00, 4'd10}, '{KW, 22'h000000, 8'hA0, 4'd10},
    '{KW, 22'h060000, 8'h00, 4'd10}, '{KY, 22'h0, 8'h0, 4'd10},
    '{KR, 22'h060000, 8'hFF, 4'd10},
    // R11 program into protected sector 5
    '{KW, 22'h000555, 8'hAA, 4'd11}, '{KW, 22'h0002AA, 8'h55, 4'd11},
    '{KW, 22'h000555, 8'hA0, 4'd11}, '{KW, 22'h050000, 8'h00, 4'd11},
    '{KB, 22'h0, 8'h0, 4'd11}, '{KWR, 22'h0, 8'h0, 4'd11},
    '{KR, 22'h050000, 8'hFF, 4'd11},
    // R8 writes during a program are dropped
    '{KW, 22'h000555, 8'hAA, 4'd8}, '{KW, 22'h0002AA, 8'h55, 4'd8},
    '{KW, 22'h000555, 8'hA0, 4'd8}, '{KW, 22'h070000, 8'h0F, 4'd8},
    '{KW, 22'h070001, 8'h00, 4'd8}, '{KW, 22'h000555, 8'hAA, 4'd8},
    '{KWR, 22'h0, 8'h0, 4'd8}, '{KR, 22'h070001, 8'hFF, 4'd8},
    '{KR, 22'h070000, 8'h0F, 4'd8},
    // R9 pause, program elsewhere, resume
    '{KW, 22'h000555, 8'hAA, 4'd9}, '{KW, 22'h0002AA, 8'h55, 4'd9},
    '{KW, 22'h000555, 8'hA0, 4'd9}, '{KW, 22'h080000, 8'h00, 4'd9},
    '{KWR, 22'h0, 8'h0, 4'd9},
    '{KW, 22'h000555, 8'hAA, 4'd9}, '{KW, 22'h0002AA, 8'h55, 4'd9},
    '{KW, 22'h000555, 8'h80, 4'd9}, '{KW, 22'h000555, 8'hAA, 4'd9},
    '{KW, 22'h0002AA, 8'h55, 4'd9}, '{KW, 22'h080000, 8'h30, 4'd9},
    '{KB, 22'h0, 8'h0, 4'd9}, '{KW, 22'h000000, 8'hB0, 4'd9},
    '{KY, 22'h0, 8'h0, 4'd9}, '{KR, 22'h080000, 8'h00, 4'd9},
    '{KW, 22'h000555, 8'hAA, 4'd9}, '{KW, 22'h0002AA, 8'h55, 4'd9},
    '{KW, 22'h000555, 8'hA0, 4'd9}, '{KW, 22'h090000, 8'h66, 4'd9},
    '{KWR, 22'h0, 8'h0, 4'd9}, '{KY, 22'h0, 8'h0, 4'd9},
    '{KR, 22'h090000, 8'h66, 4'd9}, '{KW, 22'h000000, 8'h30, 4'd9},
    '{KB, 22'h0, 8'h0, 4'd9}, '{KWR, 22'h0, 8'h0, 4'd9},
    '{KR, 22'h080000, 8'hFF, 4'd9}, '{KR, 22'h090000, 8'h66, 4'd9},
    // R7 whole-chip erase
    '{KW, 22'h000555, 8'hAA, 4'd7}, '{KW, 22'h0002AA, 8'h55, 4'd7},
    '{KW, 22'h000555, 8'h80, 4'd7}, '{KW, 22'h000555, 8'hAA, 4'd7},
    '{KW, 22'h0002AA, 8'h55, 4'd7}, '{KW, 22'h000555, 8'h10, 4'd7},
    '{KB, 22'h0, 8'h0, 4'd7}, '{KWR, 22'h0, 8'h0, 4'd7},
    '{KR, 22'h040000, 8'hFF, 4'd7}, '{KR, 22'h090000, 8'hFF, 4'd7},
    '{KR, 22'h060003, 8'hFF, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1;
  logic [21:0] addr = '0;
  logic [7:0]  din = '0;
  logic [63:0] sect_prot = 64'h20;
  logic [7:0]  dout;
  logic        dout_oe, rdy;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .addr(addr), .din(din), .sect_prot(sect_prot),
    .dout(dout), .dout_oe(dout_oe), .rdy(rdy)
  );

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [21:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    idle(4);
    we_n = 1'b1;
    idle(4);
    ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [21:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(5);
    check(dout_oe === 1'b1 && dout === e, req, dout, e);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wait_rdy(input string req);
    int n = 0;
    while (rdy !== 1'b1 && n < 2000) begin
      @(negedge clk); n++;
    end
    check(rdy === 1'b1, req, {7'd0, rdy}, 8'h01);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state: ready, outputs quiet
    check(rdy === 1'b1, "R1", {7'd0, rdy}, 8'h01);
    check(dout_oe === 1'b0, "R1", {7'd0, dout_oe}, 8'h00);

    for (int i = 0; i < N; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", VEC[i].r, i);
      case (VEC[i].k)
        KW:  bus_write(VEC[i].a, VEC[i].d);
        KR:  bus_read(VEC[i].a, VEC[i].d, tag);
        KWR: wait_rdy(tag);
        KB:  begin idle(1); check(rdy === 1'b0, tag, {7'd0, rdy}, 8'h00); end
        default: begin idle(1); check(rdy === 1'b1, tag, {7'd0, rdy}, 8'h01); end
      endcase
    end

    // R4 and R5: hardware reset during a program
    bus_write(22'h000555, 8'hAA);
    bus_write(22'h0002AA, 8'h55);
    bus_write(22'h000555, 8'hA0);
    bus_write(22'h0A0000, 8'h00);
    idle(1);
    check(rdy === 1'b0, "R5 busy before reset", {7'd0, rdy}, 8'h00);
    hw_rst_n = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0; addr = 22'h0A0000;
    idle(5);
    check(dout_oe === 1'b0, "R4 outputs quiet in reset", {7'd0, dout_oe}, 8'h00);
    check(rdy === 1'b0, "R5 busy held in reset", {7'd0, rdy}, 8'h00);
    oe_n = 1'b1; ce_n = 1'b1;
    // writes during reset must be ignored (R4)
    bus_write(22'h000555, 8'hAA);
    bus_write(22'h0002AA, 8'h55);
    bus_write(22'h000555, 8'h90);
    hw_rst_n = 1'b1;
    idle(30);
    check(rdy === 1'b1, "R5 ready after interval", {7'd0, rdy}, 8'h01);
    bus_read(22'h0A0000, 8'hFF, "R4 program aborted");
    bus_read(22'h000001, 8'hFF, "R4 read-array after release");

    // R5 hold length: reset right after a program starts
    bus_write(22'h000555, 8'hAA);
    bus_write(22'h0002AA, 8'h55);
    bus_write(22'h000555, 8'hA0);
    bus_write(22'h0A0001, 8'h00);
    hw_rst_n = 1'b0;
    idle(2);
    hw_rst_n = 1'b1;
    idle(3);
    check(rdy === 1'b0, "R5 still busy after release", {7'd0, rdy}, 8'h00);
    idle(15);
    check(rdy === 1'b1, "R5 ready after interval", {7'd0, rdy}, 8'h01);

    // R5 idle reset: ready never drops
    hw_rst_n = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check(rdy === 1'b1, "R5 idle reset", {7'd0, rdy}, 8'h01);
    end
    hw_rst_n = 1'b1;
    idle(4);
    bus_read(22'h0A0001, 8'hFF, "R4 second abort");

    summary();
  end

endmodule